// File: doc/BRIEF.md
# Receive Ring Buffer Pointer Unit

This block keeps the pointers of a circular receive region that lives inside a shared packet memory. A host programs the region through a byte-wide register port: a lower bound, an upper bound and a 16-bit read pointer. The receive side sends one store request per byte. The unit answers each request with a write strobe and the address where that byte goes. It then moves its write pointer on and wraps it from the upper bound back to the lower bound.

The unit also reports how many bytes can still be written before the write pointer would reach the read pointer. A store request that finds no room is dropped and leaves a sticky overflow flag set. Any bound write that breaks the alignment rule (lower bound even, upper bound odd) sets a sticky error flag, and the alignment bit keeps its old value.

Top module: `rx_ring_ptr_unit`

## Requirements
- R1: After reset, every pointer output, the free count, the write strobe, the ready flag, the overflow flag and the error flag are all zero.
- R2: A register write with `reg_sel_i` = 0 or 1 loads the low or high byte of the lower bound. Codes 2 and 3 load the low or high byte of the upper bound. Codes 6 and 7 change nothing.
- R3: A write to any byte of either bound sets the write pointer, on the next cycle, to the lower bound value as it stands after that write. This reload takes priority over a store in the same cycle.
- R4: A write with code 4 puts the byte in a shadow register and leaves `rd_ptr_o` unchanged. A write with code 5 loads `rd_ptr_o` with the written byte as its high byte and the shadow as its low byte, in one step.
- R5: `ready_o` rises only after each bound has received at least one write. Until then, store requests are dropped, the write pointer stays put, no overflow is flagged and `free_o` reads zero.
- R6: An accepted store raises `wr_en_o` in the same cycle, with `wr_addr_o` holding the current write pointer. On the next cycle the pointer moves to the next address.
- R7: An accepted store while the write pointer equals the upper bound moves the pointer to the lower bound on the next cycle.
- R8: While ready, `free_o` = (read pointer − write pointer) modulo N, where N = upper − lower + 1. With the read pointer at the upper bound and the write pointer at the lower bound this gives N − 1. When the two pointers are equal it gives 0.
- R9: A store request while ready and with `free_o` = 0 is dropped: `wr_en_o` stays low, the pointer holds, and `overflow_o` is set and stays set until reset.
- R10: A low-byte write to the lower bound with bit 0 = 1, or to the upper bound with bit 0 = 0, sets `align_err_o`. That bit 0 of the bound keeps its previous value while the other bits are written. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_sel_i | input | 3 | Register select code |
| reg_wdata_i | input | 8 | Host write byte |
| store_i | input | 1 | Request to store one received byte |
| ready_o | output | 1 | Both bounds have been programmed |
| wr_en_o | output | 1 | Store accepted this cycle |
| wr_addr_o | output | 16 | Write pointer (address of the next stored byte) |
| start_o | output | 16 | Lower bound of the region |
| end_o | output | 16 | Upper bound of the region |
| rd_ptr_o | output | 16 | Committed read pointer |
| free_o | output | 17 | Free bytes between the write and read pointers |
| overflow_o | output | 1 | Sticky: a store was dropped for lack of room |
| align_err_o | output | 1 | Sticky: a bound write broke the alignment rule |

## Verification
The hardest state to reach is a full ring whose write pointer has wrapped, with a read pointer commit landing in the same cycle as a store. The bench gets there by programming a 16-byte region and filling it until the free count hits zero. It then issues an extra store to set the overflow flag, moves the read pointer back through the shadow and commit writes, and stores across the upper bound. After that directed run, a long random mix of stores, read-pointer commits, reprogramming with valid and misaligned bounds, and writes to unused codes is checked cycle by cycle against a behavioural model.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [2:0] {
    SEL_LO_BOUND_L = 3'd0,
    SEL_LO_BOUND_H = 3'd1,
    SEL_HI_BOUND_L = 3'd2,
    SEL_HI_BOUND_H = 3'd3,
    SEL_RDP_L      = 3'd4,
    SEL_RDP_H      = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/rxr_bound_reg.sv
module rxr_bound_reg #(
  parameter int PTR_W   = 16,
  parameter bit REQ_LSB = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [7:0]       wdata_i,
  output logic [PTR_W-1:0] val_o,
  output logic [PTR_W-1:0] val_nxt_o,
  output logic             written_o,
  output logic             bad_o
);
  localparam int HI_W = PTR_W - 8;

  logic [PTR_W-1:0] val_q;
  logic             written_q;

  assign bad_o = wr_lo_i && (wdata_i[0] != REQ_LSB);

  always_comb begin
    val_nxt_o = val_q;
    if (wr_lo_i) val_nxt_o[7:0] = {wdata_i[7:1], bad_o ? val_q[0] : wdata_i[0]};
    if (wr_hi_i) val_nxt_o[PTR_W-1:8] = HI_W'(wdata_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q     <= '0;
      written_q <= 1'b0;
    end else begin
      val_q <= val_nxt_o;
      if (wr_lo_i || wr_hi_i) written_q <= 1'b1;
    end
  end

  assign val_o     = val_q;
  assign written_o = written_q;

  p_lsb_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_o |=> $stable(val_o[0]));
endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       sel_i,
  input  logic [7:0]       wdata_i,
  output logic [PTR_W-1:0] start_o,
  output logic [PTR_W-1:0] start_nxt_o,
  output logic [PTR_W-1:0] end_o,
  output logic [PTR_W-1:0] rd_o,
  output logic             bound_wr_o,
  output logic             cfg_ok_o,
  output logic             align_err_o
);
  localparam int HI_W = PTR_W - 8;

  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  logic wr_sl, wr_sh, wr_el, wr_eh, wr_rl, wr_rh;
  assign wr_sl = we_i && (sel == SEL_LO_BOUND_L);
  assign wr_sh = we_i && (sel == SEL_LO_BOUND_H);
  assign wr_el = we_i && (sel == SEL_HI_BOUND_L);
  assign wr_eh = we_i && (sel == SEL_HI_BOUND_H);
  assign wr_rl = we_i && (sel == SEL_RDP_L);
  assign wr_rh = we_i && (sel == SEL_RDP_H);

  logic [PTR_W-1:0] end_nxt;
  logic             s_done, e_done, s_bad, e_bad;

  rxr_bound_reg #(.PTR_W(PTR_W), .REQ_LSB(1'b0)) u_lo_bound (
    .clk_i, .rst_ni, .wr_lo_i(wr_sl), .wr_hi_i(wr_sh), .wdata_i,
    .val_o(start_o), .val_nxt_o(start_nxt_o), .written_o(s_done), .bad_o(s_bad)
  );

  rxr_bound_reg #(.PTR_W(PTR_W), .REQ_LSB(1'b1)) u_hi_bound (
    .clk_i, .rst_ni, .wr_lo_i(wr_el), .wr_hi_i(wr_eh), .wdata_i,
    .val_o(end_o), .val_nxt_o(end_nxt), .written_o(e_done), .bad_o(e_bad)
  );

  logic [7:0]       shadow_q;
  logic [PTR_W-1:0] rd_q;
  logic             err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      rd_q     <= '0;
      err_q    <= 1'b0;
    end else begin
      if (wr_rl) shadow_q <= wdata_i;
      if (wr_rh) rd_q <= {HI_W'(wdata_i), shadow_q};
      if (s_bad || e_bad) err_q <= 1'b1;
    end
  end

  assign rd_o        = rd_q;
  assign align_err_o = err_q;
  assign bound_wr_o  = wr_sl || wr_sh || wr_el || wr_eh;
  assign cfg_ok_o    = s_done && e_done;

  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 3'd4) |=> $stable(rd_o));
  p_rd_commit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 3'd5) |=> (rd_o[7:0] == $past(shadow_q)));
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_err_o |=> align_err_o);
  p_lsb_even_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o[0] == 1'b0);
endmodule

// File: rtl/rxr_space.sv
module rxr_space #(
  parameter int PTR_W = 16
) (
  input  logic             ready_i,
  input  logic [PTR_W-1:0] start_i,
  input  logic [PTR_W-1:0] end_i,
  input  logic [PTR_W-1:0] rd_i,
  input  logic [PTR_W-1:0] wp_i,
  output logic [PTR_W:0]   size_o,
  output logic [PTR_W:0]   free_o,
  output logic             free_zero_o
);
  logic [PTR_W:0] diff;

  assign size_o = {1'b0, end_i} - {1'b0, start_i} + (PTR_W+1)'(1);
  assign diff   = {1'b0, rd_i} - {1'b0, wp_i};

  always_comb begin
    if (!ready_i)          free_o = '0;
    else if (rd_i >= wp_i) free_o = diff;
    else                   free_o = diff + size_o;
  end

  assign free_zero_o = (free_o == '0);
endmodule

// File: rtl/rxr_wptr.sv
module rxr_wptr #(
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reload_i,
  input  logic [PTR_W-1:0] reload_val_i,
  input  logic             store_i,
  input  logic             ready_i,
  input  logic             full_i,
  input  logic [PTR_W-1:0] start_i,
  input  logic [PTR_W-1:0] end_i,
  output logic [PTR_W-1:0] wp_o,
  output logic             wr_en_o,
  output logic             ovf_o
);
  logic [PTR_W-1:0] wp_q;
  logic             ovf_q;

  assign wr_en_o = store_i && ready_i && !full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (reload_i)     wp_q <= reload_val_i;
      else if (wr_en_o) wp_q <= (wp_q == end_i) ? start_i : wp_q + PTR_W'(1);
      if (store_i && ready_i && full_i) ovf_q <= 1'b1;
    end
  end

  assign wp_o  = wp_q;
  assign ovf_o = ovf_q;

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (wp_o == $past(reload_val_i)));
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !reload_i && wp_o == end_i) |=> (wp_o == $past(start_i)));
  p_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !reload_i && wp_o != end_i) |=> (wp_o == $past(wp_o) + PTR_W'(1)));
  p_ovf_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);
  p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_i && !reload_i) |=> $stable(wp_o));
endmodule

// File: rtl/rx_ring_ptr_unit.sv
module rx_ring_ptr_unit #(
  parameter int PTR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_sel_i,
  input  logic [7:0]       reg_wdata_i,
  input  logic             store_i,
  output logic             ready_o,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] start_o,
  output logic [PTR_W-1:0] end_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W:0]   free_o,
  output logic             overflow_o,
  output logic             align_err_o
);
  logic [PTR_W-1:0] start_nxt, wp;
  logic [PTR_W:0]   size;
  logic             bound_wr, full;

  rxr_regs #(.PTR_W(PTR_W)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .start_o, .start_nxt_o(start_nxt), .end_o, .rd_o(rd_ptr_o),
    .bound_wr_o(bound_wr), .cfg_ok_o(ready_o), .align_err_o
  );

  rxr_space #(.PTR_W(PTR_W)) u_space (
    .ready_i(ready_o), .start_i(start_o), .end_i(end_o), .rd_i(rd_ptr_o),
    .wp_i(wp), .size_o(size), .free_o, .free_zero_o(full)
  );

  rxr_wptr #(.PTR_W(PTR_W)) u_wptr (
    .clk_i, .rst_ni, .reload_i(bound_wr), .reload_val_i(start_nxt),
    .store_i, .ready_i(ready_o), .full_i(full), .start_i(start_o), .end_i(end_o),
    .wp_o(wp), .wr_en_o, .ovf_o(overflow_o)
  );

  assign wr_addr_o = wp;

  p_no_store_full_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (free_o != '0));
  p_free_le_size_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_o <= end_o && rd_ptr_o >= start_o && rd_ptr_o <= end_o
     && wr_addr_o >= start_o && wr_addr_o <= end_o) |-> (free_o < size));
  p_ready_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  p_free_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !reg_we_i) |=> (free_o == $past(free_o) - (PTR_W+1)'(1)));
endmodule

// File: tb/sim_rx_ring_ptr_unit.sv
module sim_rx_ring_ptr_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic        store = 1'b0;
  logic        ready, wr_en, ovf, aerr;
  logic [15:0] wr_addr, start_v, end_v, rd_v;
  logic [16:0] free_v;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  logic [15:0] m_start = '0, m_end = '0, m_rd = '0, m_wp = '0;
  logic [7:0]  m_shadow = '0;
  bit          m_sw = 0, m_ew = 0, m_ovf = 0, m_err = 0;

  always #2 clk = ~clk;

  rx_ring_ptr_unit u0 (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .store_i(store), .ready_o(ready), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .start_o(start_v), .end_o(end_v), .rd_ptr_o(rd_v), .free_o(free_v),
    .overflow_o(ovf), .align_err_o(aerr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int m_free();
    int n, f;
    if (!(m_sw && m_ew)) return 0;
    n = int'(m_end) - int'(m_start) + 1;
    f = int'(m_rd) - int'(m_wp);
    if (f < 0) f += n;
    return f & 32'h1FFFF;
  endfunction

  function automatic bit m_accept();
    return store && m_sw && m_ew && (m_free() != 0);
  endfunction

  task automatic compare_all();
    chk("R5 ready", int'(ready), int'(m_sw && m_ew));
    chk("R6 wr_en", int'(wr_en), int'(m_accept()));
    chk("R6 wr_addr/R3/R7", int'(wr_addr), int'(m_wp));
    chk("R2 start", int'(start_v), int'(m_start));
    chk("R2 end", int'(end_v), int'(m_end));
    chk("R4 rd_ptr", int'(rd_v), int'(m_rd));
    chk("R8 free", int'(free_v), m_free());
    chk("R9 overflow", int'(ovf), int'(m_ovf));
    chk("R10 align_err", int'(aerr), int'(m_err));
  endtask

  task automatic model_edge();
    logic [7:0] v;
    bit acc, full_hit, bwr;
    acc = m_accept();
    full_hit = store && m_sw && m_ew && (m_free() == 0);
    bwr = 0;
    v = reg_wdata;
    if (reg_we) begin
      case (reg_sel)
        3'd0: begin
          if (v[0]) begin m_err = 1; v[0] = m_start[0]; end
          m_start[7:0] = v; m_sw = 1; bwr = 1;
        end
        3'd1: begin m_start[15:8] = v; m_sw = 1; bwr = 1; end
        3'd2: begin
          if (!v[0]) begin m_err = 1; v[0] = m_end[0]; end
          m_end[7:0] = v; m_ew = 1; bwr = 1;
        end
        3'd3: begin m_end[15:8] = v; m_ew = 1; bwr = 1; end
        3'd4: m_shadow = v;
        3'd5: m_rd = {v, m_shadow};
        default: ;
      endcase
    end
    if (full_hit) m_ovf = 1;
    if (bwr) m_wp = m_start;
    else if (acc) m_wp = (m_wp == m_end) ? m_start : m_wp + 16'd1;
  endtask

  // one cycle: drive after falling edge, compare, then advance model at rising edge
  task automatic step(input bit we, input logic [2:0] sel, input logic [7:0] d, input bit st);
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = d; store = st;
    #1;
    compare_all();
    model_edge();
    @(posedge clk);
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    step(1, sel, d, 0);
  endtask

  task automatic idle();
    step(0, 3'd0, 8'd0, 0);
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1: reset values
    chk("R1 wr_addr", int'(wr_addr), 0);
    chk("R1 rd_ptr", int'(rd_v), 0);
    chk("R1 free", int'(free_v), 0);
    chk("R1 flags", int'({ready, wr_en, ovf, aerr}), 0);
    rst_ni = 1'b1;

    // R5: stores before configuration are dropped
    step(0, 3'd0, 8'd0, 1);
    step(0, 3'd0, 8'd0, 1);
    wr(3'd0, 8'h11);            // R10: odd lower bound, lsb kept 0
    wr(3'd1, 8'h01);
    step(0, 3'd0, 8'd0, 1);     // R5: still not ready
    wr(3'd2, 8'h1F);
    wr(3'd3, 8'h01);            // region 0x0110..0x011F, N=16
    wr(3'd2, 8'h1E);            // R10: even upper bound, lsb kept 1
    wr(3'd6, 8'hAA);            // R2: unused codes
    wr(3'd7, 8'h55);
    wr(3'd4, 8'h1F);            // R4: shadow only
    idle();
    chk("R4 rd held after low write", int'(rd_v), 0);
    wr(3'd5, 8'h01);
    idle();
    #1;
    chk("R4 rd committed", int'(rd_v), 16'h011F);
    chk("R8 free N-1", int'(free_v), 15);
    chk("R10 lsb kept end", int'(end_v), 16'h011F);
    chk("R10 lsb kept start", int'(start_v), 16'h0110);

    for (int i = 0; i < 15; i++) step(0, 3'd0, 8'd0, 1);
    idle();
    #1;
    chk("R9 full free", int'(free_v), 0);
    chk("R9 full wptr", int'(wr_addr), 16'h011F);
    step(0, 3'd0, 8'd0, 1);     // R9: dropped
    idle();
    #1;
    chk("R9 overflow set", int'(ovf), 1);

    wr(3'd4, 8'h18);
    wr(3'd5, 8'h01);            // rd=0x0118, free=9
    step(0, 3'd0, 8'd0, 1);     // R7: store at upper bound
    idle();
    #1;
    chk("R7 wrapped", int'(wr_addr), 16'h0110);
    step(1, 3'd4, 8'h12, 1);    // store with shadow write
    step(1, 3'd5, 8'h01, 1);    // store with commit same cycle
    step(1, 3'd1, 8'h01, 1);    // R3: reload beats store
    idle();
    #1;
    chk("R3 reload", int'(wr_addr), 16'h0110);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic [15:0] span, rp;
      r = int'($urandom_range(0, 99));
      span = m_end - m_start + 16'd1;
      rp = m_start + 16'($urandom_range(0, int'(span) - 1));
      if (r < 60) step(0, 3'd0, 8'd0, 1);
      else if (r < 75) begin
        wr(3'd4, rp[7:0]);
        step(1, 3'd5, rp[15:8], $urandom_range(0, 1) == 1);
      end else if (r < 80) begin
        logic [15:0] s, e;
        s = 16'($urandom_range(0, 255)) << 1;
        e = s + (16'($urandom_range(1, 60)) << 1) - 16'd1;
        if ($urandom_range(0, 3) == 0) s[0] = 1'b1;
        wr(3'd1, s[15:8]); wr(3'd0, s[7:0]);
        wr(3'd3, e[15:8]); wr(3'd2, e[7:0]);
        wr(3'd4, m_end[7:0]); wr(3'd5, m_end[15:8]);
      end else if (r < 85) wr(3'($urandom_range(6, 7)), 8'($urandom_range(0, 255)));
      else idle();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule